// File: doc/BRIEF.md
# Registered Sixteen-Bit Opcode ALU

This block is a synchronous arithmetic-logic unit with a register on each side of its datapath. On every rising clock edge it captures two 16-bit operands, a carry-in bit and a 4-bit operation code into an input register stage. Between that stage and an output register stage a combinational datapath evaluates the selected operation. Results are addition with carry, subtraction, equality and inequality tests, five bitwise functions and a pass-through of either operand. The datapath produces a 16-bit result, a carry-out, a zero flag and a compare bit, and all four are loaded into the output registers on the next edge.

A result appears at the outputs two rising edges after its operands are presented. The carry chain through the adder is the longest combinational path. Codes that have no operation assigned drive every output to zero. This gives a known, quiet output for any code that is not in use.

Top module: `alu16_reg`

## Requirements
- R1: A synchronous active-low reset clears every input and output register, so `res_o`, `carry_o`, `zero_o` and `cmp_o` read 0 on the edge after `rst_n` is sampled low.
- R2: Code 4'h0 gives `res_o` = (A + B + carry-in) mod 2^16, and `carry_o` is the 17th bit of that sum.
- R3: Code 4'h1 gives `res_o` = (A − B) mod 2^16, computed as A + ~B + 1 with carry-in ignored; `carry_o` is 1 exactly when A ≥ B (unsigned), that is when no borrow occurs.
- R4: Code 4'h2 sets `cmp_o` to 1 when A equals B, and code 4'h3 sets `cmp_o` to 1 when A differs from B; for both codes `res_o` is 0 and `carry_o` is 0.
- R5: Bitwise codes give XOR (4'h4), NOR (4'h5), OR (4'h6), AND (4'h7) and NAND (4'hA) of A and B on `res_o`.
- R6: Code 4'h8 places A on `res_o`, and code 4'h9 places B on `res_o`.
- R7: Codes 4'hB to 4'hF drive `res_o`, `carry_o`, `zero_o` and `cmp_o` all to 0.
- R8: For the defined codes 4'h0 to 4'hA, `zero_o` is 1 exactly when `res_o` is all zeros.
- R9: Operands, carry-in and code are registered, so a result appears on the outputs after the second rising edge following the inputs and holds until the next edge.
- R10: `carry_o` and `cmp_o` are 0 for every bitwise and pass-through code, and `cmp_o` is 0 for add and subtract.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for both register stages |
| rst_n | input | 1 | Synchronous reset, active low |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| cin_i | input | 1 | Carry-in, used by the add code only |
| op_i | input | 4 | Operation code |
| res_o | output | 16 | Registered result C |
| carry_o | output | 1 | Registered carry-out |
| zero_o | output | 1 | Registered zero flag |
| cmp_o | output | 1 | Registered compare answer |

## Verification
Assertions check several properties on every clock. They check the full 17-bit add result against the operands held in the input stage one edge earlier, and the equality answer against those same held operands. They also check that unused codes silence every output, that compare codes leave the result at zero, that bitwise and pass-through codes leave carry and compare low, that a raised zero flag always comes with a zero result, and that outputs are clear right after reset. Other behaviours need the bench's scenarios. These are the exact values of subtraction and its borrow sense, the exact value of each bitwise function, the two-edge latency across a stream of changing inputs, a reset pulse in the middle of traffic, and boundary operands such as all-ones plus one and equal operands under subtract.

// File: rtl/alu16_pkg.sv
// Package: shared width and operation codes of the registered ALU.
// Assumes a 4-bit code; values above OP_NAND have no operation assigned.
package alu16_pkg;
    parameter int unsigned ALU_W  = 16;
    parameter int unsigned CODE_W = 4;

    localparam logic [CODE_W-1:0] OP_ADD   = 4'h0;
    localparam logic [CODE_W-1:0] OP_SUB   = 4'h1;
    localparam logic [CODE_W-1:0] OP_EQ    = 4'h2;
    localparam logic [CODE_W-1:0] OP_NE    = 4'h3;
    localparam logic [CODE_W-1:0] OP_XOR   = 4'h4;
    localparam logic [CODE_W-1:0] OP_NOR   = 4'h5;
    localparam logic [CODE_W-1:0] OP_OR    = 4'h6;
    localparam logic [CODE_W-1:0] OP_AND   = 4'h7;
    localparam logic [CODE_W-1:0] OP_PASSA = 4'h8;
    localparam logic [CODE_W-1:0] OP_PASSB = 4'h9;
    localparam logic [CODE_W-1:0] OP_NAND  = 4'hA;

    // Flags that travel beside the result word
    typedef struct packed {
        logic carry;
        logic zero;
        logic cmp;
    } alu_flags_t;
endpackage

// File: rtl/alu16_in_reg.sv
// Module: input register stage. Captures operands, carry-in and code on
// each rising edge. Assumes a synchronous active-low reset.
module alu16_in_reg #(
    parameter int unsigned W  = alu16_pkg::ALU_W,
    parameter int unsigned CW = alu16_pkg::CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  a_d,
    input  logic [W-1:0]  b_d,
    input  logic          cin_d,
    input  logic [CW-1:0] op_d,
    output logic [W-1:0]  a_q,
    output logic [W-1:0]  b_q,
    output logic          cin_q,
    output logic [CW-1:0] op_q
);
    // Capture the operation request, or clear it on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            cin_q <= 1'b0;
            op_q  <= '0;
        end else begin
            a_q   <= a_d;
            b_q   <= b_d;
            cin_q <= cin_d;
            op_q  <= op_d;
        end
    end
endmodule

// File: rtl/alu16_adder.sv
// Module: ripple-carry adder built bit by bit. Assumes W >= 1; the carry
// out is the carry leaving the top bit.
module alu16_adder #(
    parameter int unsigned W = alu16_pkg::ALU_W
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co
);
    logic [W:0] chain;

    assign chain[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // One full-adder cell of the chain
        assign sum[i]     = x[i] ^ y[i] ^ chain[i];
        assign chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
    end

    assign co = chain[W];
endmodule

// File: rtl/alu16_core.sv
// Module: combinational datapath. Decodes the code, drives the shared
// adder for add and subtract, and forms the result and flags. Assumes
// codes above OP_NAND are unused and must give all-zero outputs.
module alu16_core
    import alu16_pkg::*;
#(
    parameter int unsigned W  = ALU_W,
    parameter int unsigned CW = CODE_W
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic          cin,
    input  logic [CW-1:0] op,
    output logic [W-1:0]  res,
    output alu_flags_t    flags
);
    logic         is_sub;
    logic [W-1:0] y_add;
    logic         ci_add;
    logic [W-1:0] sum;
    logic         co;
    logic         defined;

    // Subtract reuses the adder with B inverted and a forced carry of one
    always_comb begin
        is_sub = (op == OP_SUB);
        y_add  = is_sub ? ~b : b;
        ci_add = is_sub ? 1'b1 : cin;
    end

    alu16_adder #(.W(W)) u_add (
        .x   (a),
        .y   (y_add),
        .ci  (ci_add),
        .sum (sum),
        .co  (co)
    );

    // Select the result word, carry and compare answer for the code
    always_comb begin
        res         = '0;
        flags.carry = 1'b0;
        flags.cmp   = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                res         = sum;
                flags.carry = co;
            end
            OP_EQ:    flags.cmp = (a == b);
            OP_NE:    flags.cmp = (a != b);
            OP_XOR:   res = a ^ b;
            OP_NOR:   res = ~(a | b);
            OP_OR:    res = a | b;
            OP_AND:   res = a & b;
            OP_PASSA: res = a;
            OP_PASSB: res = b;
            OP_NAND:  res = ~(a & b);
            default:  res = '0;
        endcase
    end

    // Zero flag only for codes that have an operation
    always_comb begin
        defined    = (op <= OP_NAND);
        flags.zero = defined && (res == '0);
    end
endmodule

// File: rtl/alu16_out_reg.sv
// Module: output register stage holding result and flags. Assumes a
// synchronous active-low reset that clears every output.
module alu16_out_reg
    import alu16_pkg::*;
#(
    parameter int unsigned W = ALU_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] res_d,
    input  alu_flags_t   flags_d,
    output logic [W-1:0] res_q,
    output alu_flags_t   flags_q
);
    // Hold the datapath answer for one cycle, or clear it on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            res_q   <= res_d;
            flags_q <= flags_d;
        end
    end

    // R8
    zero_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q.zero |-> (res_q == '0));
endmodule

// File: rtl/alu16_reg.sv
// Module: top of the registered ALU. Input stage, datapath, output stage;
// results appear two rising edges after their inputs. Assumes a
// synchronous active-low reset.
module alu16_reg
    import alu16_pkg::*;
#(
    parameter int unsigned W  = ALU_W,
    parameter int unsigned CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          cin_i,
    input  logic [CW-1:0] op_i,
    output logic [W-1:0]  res_o,
    output logic          carry_o,
    output logic          zero_o,
    output logic          cmp_o
);
    logic [W-1:0]  a_q;
    logic [W-1:0]  b_q;
    logic          cin_q;
    logic [CW-1:0] op_q;
    logic [W-1:0]  res_d;
    alu_flags_t    flags_d;
    alu_flags_t    flags_q;

    alu16_in_reg #(.W(W), .CW(CW)) u_in (
        .clk   (clk),
        .rst_n (rst_n),
        .a_d   (a_i),
        .b_d   (b_i),
        .cin_d (cin_i),
        .op_d  (op_i),
        .a_q   (a_q),
        .b_q   (b_q),
        .cin_q (cin_q),
        .op_q  (op_q)
    );

    alu16_core #(.W(W), .CW(CW)) u_core (
        .a     (a_q),
        .b     (b_q),
        .cin   (cin_q),
        .op    (op_q),
        .res   (res_d),
        .flags (flags_d)
    );

    alu16_out_reg #(.W(W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .res_d   (res_d),
        .flags_d (flags_d),
        .res_q   (res_o),
        .flags_q (flags_q)
    );

    // Unpack the flag bundle onto the ports
    always_comb begin
        carry_o = flags_q.carry;
        zero_o  = flags_q.zero;
        cmp_o   = flags_q.cmp;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (res_o == '0 && !carry_o && !zero_o && !cmp_o));

    // R2
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_ADD) |=>
        ({carry_o, res_o} == ({1'b0, $past(a_q)} + {1'b0, $past(b_q)} + {{W{1'b0}}, $past(cin_q)})));

    // R4
    eq_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_EQ) |=> (cmp_o == ($past(a_q) == $past(b_q))));

    // R4
    compare_quiet_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_EQ || op_q == OP_NE) |=> (res_o == '0 && !carry_o && zero_o));

    // R7
    unused_code_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q > OP_NAND) |=> (res_o == '0 && !carry_o && !zero_o && !cmp_o));

    // R10
    logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q >= OP_XOR && op_q <= OP_NAND) |=> (!carry_o && !cmp_o));
endmodule

// File: tb/alu16_reg_test.sv
`timescale 1ns/1ps
module alu16_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic        cin_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [15:0] res_o;
    logic        carry_o, zero_o, cmp_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    alu16_reg uut (
        .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
        .op_i(op_i), .res_o(res_o), .carry_o(carry_o), .zero_o(zero_o), .cmp_o(cmp_o)
    );

    // Behavioural reference: stage of captured inputs, then expected outputs
    int s_a = 0, s_b = 0, s_cin = 0, s_op = 0;
    int e_c = 0, e_carry = 0, e_zero = 0, e_cmp = 0, e_op = 0;
    bit e_rst = 1;

    task automatic evaluate(input int a, input int b, input int cin, input int op,
                            output int c, output int cy, output int z, output int cp);
        int s;
        c = 0; cy = 0; cp = 0;
        case (op)
            0: begin s = a + b + cin; c = s % 65536; cy = s / 65536; end
            1: begin c = (a - b + 65536) % 65536; cy = (a >= b) ? 1 : 0; end
            2: cp = (a == b) ? 1 : 0;
            3: cp = (a != b) ? 1 : 0;
            4: c = a ^ b;
            5: c = 65535 - (a | b);
            6: c = a | b;
            7: c = a & b;
            8: c = a;
            9: c = b;
            10: c = 65535 - (a & b);
            default: c = 0;
        endcase
        z = (op <= 10 && c == 0) ? 1 : 0;
    endtask

    // Advance the reference on each rising edge (R9: two register stages)
    always @(posedge clk) begin
        if (!rst_n) begin
            s_a = 0; s_b = 0; s_cin = 0; s_op = 0;
            e_c = 0; e_carry = 0; e_zero = 0; e_cmp = 0; e_op = 0; e_rst = 1;
        end else begin
            evaluate(s_a, s_b, s_cin, s_op, e_c, e_carry, e_zero, e_cmp);
            e_op = s_op; e_rst = 0;
            s_a = a_i; s_b = b_i; s_cin = cin_i; s_op = op_i;
        end
    end

    function automatic string tag_of(input int op, input bit r);
        if (r) return "R1";
        case (op)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            4, 5, 6, 7, 10: return "R5 R10";
            8, 9: return "R6 R10";
            default: return "R7";
        endcase
    endfunction

    // Compare every output against the reference, away from the edge
    task automatic compare_now();
        string t = tag_of(e_op, e_rst);
        checks++;
        if (res_o !== e_c[15:0] || carry_o !== e_carry[0] || cmp_o !== e_cmp[0]) begin
            fails++;
            $display("FAIL %s R9 op=%0d: got c=%h cy=%b cmp=%b, expected c=%h cy=%0d cmp=%0d",
                     t, e_op, res_o, carry_o, cmp_o, e_c[15:0], e_carry, e_cmp);
        end
        checks++;
        if (zero_o !== e_zero[0]) begin
            fails++;
            $display("FAIL R8 (%s) op=%0d: got zero=%b, expected %0d", t, e_op, zero_o, e_zero);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic cin, input logic [3:0] op);
        @(negedge clk);
        compare_now();
        a_i = a; b_i = b; cin_i = cin; op_i = op;
    endtask

    initial begin
        a_i = 16'hBEEF; b_i = 16'h1234; op_i = 4'h6; cin_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs clear while reset is held
        checks++;
        if (res_o !== 16'h0 || carry_o !== 1'b0 || zero_o !== 1'b0 || cmp_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got c=%h cy=%b z=%b cmp=%b, expected all 0",
                     res_o, carry_o, zero_o, cmp_o);
        end
        rst_n = 1'b1;
        // R2: wrap-around with carry, and carry-in used
        apply(16'hFFFF, 16'h0001, 1'b0, 4'h0);
        apply(16'h1234, 16'h0F0F, 1'b1, 4'h0);
        apply(16'hFFFF, 16'hFFFF, 1'b1, 4'h0);
        // R3: equal operands, borrow case, carry-in ignored
        apply(16'h5555, 16'h5555, 1'b0, 4'h1);
        apply(16'h0001, 16'h0002, 1'b1, 4'h1);
        apply(16'h8000, 16'h0001, 1'b1, 4'h1);
        // R4: compares
        apply(16'hA5A5, 16'hA5A5, 1'b1, 4'h2);
        apply(16'hA5A5, 16'hA5A4, 1'b0, 4'h2);
        apply(16'hA5A5, 16'hA5A5, 1'b0, 4'h3);
        apply(16'h0000, 16'h0001, 1'b1, 4'h3);
        // R5 R6 R10: bitwise and pass codes
        for (int k = 4; k <= 10; k++) apply(16'hF0CC, 16'h3CAA, 1'b1, k[3:0]);
        apply(16'hFFFF, 16'h0000, 1'b0, 4'h5);
        apply(16'h0000, 16'hFFFF, 1'b0, 4'h8);
        // R7: unused codes with busy operands
        for (int k = 11; k <= 15; k++) apply(16'hFFFF, 16'hFFFF, 1'b1, k[3:0]);
        // Mixed traffic with a reset pulse in the middle (R1, R9)
        for (int n = 0; n < 2000; n++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = ($urandom_range(0, 3) == 0) ? ra : 16'($urandom);
            if (n == 1000) begin
                @(negedge clk); compare_now(); rst_n = 1'b0;
                @(negedge clk); compare_now();
                @(negedge clk); compare_now(); rst_n = 1'b1;
            end
            apply(ra, rb, 1'($urandom), 4'($urandom_range(0, 15)));
        end
        repeat (3) apply(16'h0, 16'h0, 1'b0, 4'h0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected end of run");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule